// File: doc/BRIEF.md
# Spinning Semaphore Acquire Engine

This block acquires and releases a one-bit semaphore in shared memory on behalf of its core. The location reads 1 when the guarded resource is free and 0 when some thread owns it. When the core asks for the lock, the engine polls the location with ordinary reads. These can be served from a local cache and add little traffic. Only when a read shows the free value does it issue one atomic test-and-set. That command returns the old value and leaves 0 behind in the same indivisible memory step.

If the returned old value was 1, the lock now belongs to this core. The engine pulses a grant and holds the lock until the core releases it. If another agent took the lock between the read and the atomic command, the old value is 0. The engine then goes back to polling with reads. A release writes the free value back.

The memory side carries one command at a time, using a valid/ready handshake and a separate response strobe. The core side is two single-cycle request strobes, a grant pulse and a held level. A release that arrives when the lock is not held is dropped, and it is reported on an error pulse.

Top module: `spinlock_agent`

## Requirements
- R1: While and after reset, until the first request, grant_o, held_o, busy_o, err_o and mem_cmd_valid are all low.
- R2: An acquire strobe in the idle state starts polling. Every command goes to lock_addr, and the command op codes are 0 for a plain read, 1 for test-and-set and 2 for a write.
- R3: A test-and-set (op 1) is issued only right after a plain read whose response data was 1. While reads return 0, only reads (op 0) are issued.
- R4: A test-and-set response with data 1 makes grant_o high for exactly one cycle, in the cycle after the response. held_o is high from that same cycle until the release is taken.
- R5: A test-and-set response with data 0 gives no grant, and the next command is a plain read.
- R6: At most one command is outstanding. mem_cmd_valid stays low from the cycle after a command is accepted until its response has arrived.
- R7: A release strobe while held_o is high produces one write (op 2) with mem_cmd_wdata 1 to lock_addr. After its response the engine is idle, with held_o and busy_o low.
- R8: A release strobe while held_o is low issues no command and changes no state. It raises err_o for exactly the following cycle.
- R9: An acquire strobe while held_o is high issues no command and leaves held_o high.
- R10: While mem_cmd_valid is high and mem_cmd_ready is low, the command stays presented unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_addr | input | ADDR_W | Address of the semaphore word |
| acq_i | input | 1 | Single-cycle acquire request |
| rel_i | input | 1 | Single-cycle release request |
| grant_o | output | 1 | One-cycle pulse: lock obtained |
| held_o | output | 1 | Lock currently owned by this core |
| busy_o | output | 1 | Polling, test-and-set or release in progress |
| err_o | output | 1 | One-cycle pulse: release without ownership |
| mem_cmd_valid | output | 1 | Command valid |
| mem_cmd_ready | input | 1 | Command accepted by memory side |
| mem_cmd_op | output | 2 | 0 read, 1 test-and-set, 2 write |
| mem_cmd_addr | output | ADDR_W | Command address |
| mem_cmd_wdata | output | 1 | Write data (1 on release) |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 1 | Read data / old value |

## Verification
The bench models a second agent that grabs and frees the semaphore at random. It can also pin the lock right after the engine's read has seen it free. That case forces a lost race, so a design that granted on the read instead of on the atomic result would hand out a lock another agent owns. A design that went straight back to the atomic command after a loss would issue atomics while the lock is held. Random backpressure and response delays would show a command that changes while stalled, or a second command issued before the first response. Releases sent while idle or while still polling must only raise the error pulse. Otherwise a stray release would free a lock owned elsewhere.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  typedef enum logic [2:0] {
    LK_IDLE    = 3'd0,
    LK_POLL    = 3'd1,
    LK_ATOMIC  = 3'd2,
    LK_HELD    = 3'd3,
    LK_RELEASE = 3'd4
  } lk_state_e;

  typedef enum logic [1:0] {
    MOP_READ  = 2'd0,
    MOP_TAS   = 2'd1,
    MOP_WRITE = 2'd2
  } mem_op_e;

  localparam logic LOCK_FREE  = 1'b1;
  localparam logic LOCK_TAKEN = 1'b0;

endpackage

// File: rtl/sl_seq.sv
module sl_seq
  import spinlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acq_i,
  input  logic      rel_i,
  input  logic      done_i,
  input  logic      rdata_i,
  output lk_state_e state_o,
  output logic      want_o,
  output mem_op_e   op_o,
  output logic      wdata_o,
  output logic      win_o,
  output logic      stray_o
);

  lk_state_e state_q;
  lk_state_e state_d;
  logic      state_en;

  // next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LK_IDLE:    if (acq_i) state_d = LK_POLL;
      LK_POLL:    if (done_i && (rdata_i == LOCK_FREE)) state_d = LK_ATOMIC;
      LK_ATOMIC:  if (done_i) state_d = (rdata_i == LOCK_FREE) ? LK_HELD : LK_POLL;
      LK_HELD:    if (rel_i) state_d = LK_RELEASE;
      LK_RELEASE: if (done_i) state_d = LK_IDLE;
      default:    state_d = LK_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // command selection per state
  always_comb begin
    want_o  = 1'b0;
    op_o    = MOP_READ;
    wdata_o = LOCK_TAKEN;
    unique case (state_q)
      LK_POLL:    begin want_o = 1'b1; op_o = MOP_READ;  end
      LK_ATOMIC:  begin want_o = 1'b1; op_o = MOP_TAS;   end
      LK_RELEASE: begin want_o = 1'b1; op_o = MOP_WRITE; wdata_o = LOCK_FREE; end
      default:    begin want_o = 1'b0; op_o = MOP_READ;  end
    endcase
  end

  assign win_o   = (state_q == LK_ATOMIC) && done_i && (rdata_i == LOCK_FREE);
  assign stray_o = rel_i && (state_q != LK_HELD);
  assign state_o = state_q;

endmodule

// File: rtl/sl_cmd_port.sv
module sl_cmd_port
  import spinlock_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              want_i,
  input  mem_op_e           op_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic [1:0]        mem_cmd_op,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_cmd_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_data,
  output logic              done_o,
  output logic              rdata_o
);

  logic waiting_q;
  logic waiting_d;
  logic waiting_en;
  logic accept;

  assign mem_cmd_valid = want_i && !waiting_q;
  assign accept        = mem_cmd_valid && mem_cmd_ready;
  assign done_o        = waiting_q && mem_rsp_valid;
  assign rdata_o       = mem_rsp_data;

  always_comb begin
    waiting_d = waiting_q;
    if (accept)      waiting_d = 1'b1;
    else if (done_o) waiting_d = 1'b0;
  end

  assign waiting_en = accept || done_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
    end else if (waiting_en) begin
      waiting_q <= waiting_d;
    end
  end

  assign mem_cmd_op    = op_i;
  assign mem_cmd_addr  = addr_i;
  assign mem_cmd_wdata = wdata_i;

endmodule

// File: rtl/sl_pulse_regs.sv
module sl_pulse_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  input  logic stray_i,
  output logic grant_o,
  output logic err_o
);

  logic grant_q;
  logic err_q;
  logic pulse_en;

  // only clock the pair when something is set or must clear
  assign pulse_en = win_i || stray_i || grant_q || err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (pulse_en) begin
      grant_q <= win_i;
      err_q   <= stray_i;
    end
  end

  assign grant_o = grant_q;
  assign err_o   = err_q;

endmodule

// File: rtl/spinlock_agent.sv
module spinlock_agent
  import spinlock_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              acq_i,
  input  logic              rel_i,
  output logic              grant_o,
  output logic              held_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic [1:0]        mem_cmd_op,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_cmd_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_data
);

  lk_state_e state;
  logic      want;
  mem_op_e   op;
  logic      wdata;
  logic      win;
  logic      stray;
  logic      done;
  logic      rdata;

  sl_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .acq_i   (acq_i),
    .rel_i   (rel_i),
    .done_i  (done),
    .rdata_i (rdata),
    .state_o (state),
    .want_o  (want),
    .op_o    (op),
    .wdata_o (wdata),
    .win_o   (win),
    .stray_o (stray)
  );

  sl_cmd_port #(.ADDR_W(ADDR_W)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .want_i        (want),
    .op_i          (op),
    .wdata_i       (wdata),
    .addr_i        (lock_addr),
    .mem_cmd_valid (mem_cmd_valid),
    .mem_cmd_ready (mem_cmd_ready),
    .mem_cmd_op    (mem_cmd_op),
    .mem_cmd_addr  (mem_cmd_addr),
    .mem_cmd_wdata (mem_cmd_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done_o        (done),
    .rdata_o       (rdata)
  );

  sl_pulse_regs u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_i   (win),
    .stray_i (stray),
    .grant_o (grant_o),
    .err_o   (err_o)
  );

  assign held_o = (state == LK_HELD);
  assign busy_o = (state == LK_POLL) || (state == LK_ATOMIC) || (state == LK_RELEASE);

endmodule

// File: rtl/spinlock_agent_chk.sv
module spinlock_agent_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rel_i,
  input logic       grant_o,
  input logic       held_o,
  input logic       err_o,
  input logic       mem_cmd_valid,
  input logic       mem_cmd_ready,
  input logic [1:0] mem_cmd_op,
  input logic       mem_cmd_wdata,
  input logic       mem_rsp_valid,
  input logic       mem_rsp_data
);

  logic [1:0] pend_op_q;
  logic       seen_free_q;

  // remember the op in flight and whether the last read saw the lock free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_op_q   <= 2'd2;
      seen_free_q <= 1'b0;
    end else begin
      if (mem_cmd_valid && mem_cmd_ready) begin
        pend_op_q <= mem_cmd_op;
        if (mem_cmd_op == 2'd1) seen_free_q <= 1'b0;
      end
      if (mem_rsp_valid && (pend_op_q == 2'd0)) seen_free_q <= mem_rsp_data;
    end
  end

  a_r3_tas_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && (mem_cmd_op == 2'd1)) |-> seen_free_q);

  a_r4_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);

  a_r4_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> held_o);

  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_ready) |=> !mem_cmd_valid);

  a_r7_release_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && (mem_cmd_op == 2'd2)) |-> mem_cmd_wdata);

  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_i && !held_o) |=> err_o);

  a_r10_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_op) && $stable(mem_cmd_wdata)));

endmodule

bind spinlock_agent spinlock_agent_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rel_i         (rel_i),
  .grant_o       (grant_o),
  .held_o        (held_o),
  .err_o         (err_o),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_ready (mem_cmd_ready),
  .mem_cmd_op    (mem_cmd_op),
  .mem_cmd_wdata (mem_cmd_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data)
);

// File: tb/spinlock_agent_test.sv
`timescale 1ns/1ps
module spinlock_agent_test;

  localparam int AW = 32;
  localparam logic [AW-1:0] LOCK_A = 32'h0000_4C40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acq_i = 1'b0;
  logic          rel_i = 1'b0;
  logic          grant_o, held_o, busy_o, err_o;
  logic          mem_cmd_valid;
  logic          mem_cmd_ready = 1'b0;
  logic [1:0]    mem_cmd_op;
  logic [AW-1:0] mem_cmd_addr;
  logic          mem_cmd_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_data = 1'b0;

  always #10 clk = ~clk;

  spinlock_agent #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .lock_addr(LOCK_A),
    .acq_i(acq_i), .rel_i(rel_i),
    .grant_o(grant_o), .held_o(held_o), .busy_o(busy_o), .err_o(err_o),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_op(mem_cmd_op), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  // memory and competing-agent model state
  logic       sem = 1'b1;
  bit         other_holds = 0;
  bit         pin = 0;
  bit         contend_en = 0;
  bit         steal_flag = 0;
  int         cmd_cnt = 0;
  int         tas_lost = 0;
  bit         pend = 0;
  int         delay = 0;
  logic [1:0] pend_op = 2'd2;
  logic       pend_data = 1'b0;
  logic [1:0] last_op = 2'd2;
  logic       last_res = 1'b0;
  bit         exp_grant = 0;
  bit         prev_stall = 0;
  logic [1:0] prev_op = 2'd0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit tas_allowed(input logic [1:0] lop, input logic lres);
    return (lop == 2'd0) && (lres == 1'b1);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_cmd_ready = 1'b0;
    end else begin
      // R4/R5: grant exactly one cycle after a winning atomic response
      chk(grant_o == exp_grant, "R4/R5 grant timing", grant_o, exp_grant);
      exp_grant = 0;
      // R10: stalled command still presented, unchanged
      if (prev_stall)
        chk(mem_cmd_valid && (mem_cmd_op == prev_op), "R10 stalled cmd", mem_cmd_op, prev_op);
      // R6: nothing presented while a response is pending
      if (pend) chk(!mem_cmd_valid, "R6 outstanding", mem_cmd_valid, 0);
      // response delivery
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (delay == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
          pend = 0;
          last_op = pend_op;
          last_res = pend_data;
          if (pend_op == 2'd1 && pend_data) exp_grant = 1;
          if (pend_op == 2'd1 && !pend_data) tas_lost++;
          if (pend_op == 2'd0 && pend_data && steal_flag) begin
            sem = 1'b0; other_holds = 1; pin = 1; steal_flag = 0;
          end
        end else begin
          delay--;
        end
      end
      // competing agent
      if (other_holds && !pin && ($urandom % 6 == 0)) begin
        sem = 1'b1; other_holds = 0;
      end else if (!other_holds && sem && contend_en && ($urandom % 5 == 0)) begin
        sem = 1'b0; other_holds = 1;
      end
      // command acceptance
      mem_cmd_ready = ($urandom % 4 != 0);
      if (mem_cmd_valid && mem_cmd_ready) begin
        chk(mem_cmd_addr == LOCK_A, "R2 address", mem_cmd_addr, LOCK_A);
        chk(!pend, "R6 second cmd", pend, 0);
        if (mem_cmd_op == 2'd1)
          chk(tas_allowed(last_op, last_res), "R3 atomic w/o free read", last_op, 0);
        if (last_op == 2'd1 && !last_res)
          chk(mem_cmd_op == 2'd0, "R5 read after loss", mem_cmd_op, 0);
        if (last_op == 2'd0 && !last_res)
          chk(mem_cmd_op == 2'd0, "R3 read while held", mem_cmd_op, 0);
        pend = 1;
        delay = $urandom % 3;
        pend_op = mem_cmd_op;
        cmd_cnt++;
        case (mem_cmd_op)
          2'd0: pend_data = sem;
          2'd1: begin
            pend_data = sem;
            if (sem) chk(!other_holds, "R4 exclusion", other_holds, 0);
            sem = 1'b0;
            pin = 0;
          end
          default: begin
            chk(mem_cmd_wdata == 1'b1, "R7 write data", mem_cmd_wdata, 1);
            pend_data = 1'b0;
            sem = mem_cmd_wdata;
          end
        endcase
      end
      prev_stall = mem_cmd_valid && !mem_cmd_ready;
      prev_op = mem_cmd_op;
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic do_acquire(input bit contend, input bit steal);
    int lost0;
    lost0 = tas_lost;
    contend_en = contend;
    steal_flag = steal;
    @(negedge clk) acq_i = 1'b1;
    @(negedge clk) acq_i = 1'b0;
    tick();
    chk(busy_o || held_o, "R2 acquire starts", busy_o, 1);
    for (int i = 0; i < 3000 && !held_o; i++) tick();
    chk(held_o, "R4 lock obtained", held_o, 1);
    chk(!sem && !other_holds, "R4 sole owner", other_holds, 0);
    if (steal) chk(tas_lost > lost0, "R5 lost race seen", tas_lost, lost0 + 1);
    contend_en = 0;
  endtask

  task automatic hold_for(input int n);
    int c0;
    c0 = cmd_cnt;
    @(negedge clk) acq_i = 1'b1;
    @(negedge clk) acq_i = 1'b0;
    for (int i = 0; i < n; i++) tick();
    chk(held_o, "R9 still held", held_o, 1);
    chk(cmd_cnt == c0, "R9 no command", cmd_cnt, c0);
  endtask

  task automatic do_release();
    @(negedge clk) rel_i = 1'b1;
    @(negedge clk) rel_i = 1'b0;
    for (int i = 0; i < 200 && (busy_o || held_o); i++) tick();
    tick();
    chk(!busy_o && !held_o, "R7 back to idle", busy_o, 0);
    chk(sem == 1'b1, "R7 location freed", sem, 1);
    chk(last_op == 2'd2, "R7 write issued", last_op, 2);
    chk(!err_o, "R7 no error", err_o, 0);
  endtask

  task automatic stray_release();
    int c0;
    bit h0;
    c0 = cmd_cnt;
    h0 = held_o;
    @(negedge clk) rel_i = 1'b1;
    tick();
    chk(err_o, "R8 error pulse", err_o, 1);
    @(negedge clk) rel_i = 1'b0;
    tick();
    chk(!err_o, "R8 error one cycle", err_o, 0);
    chk(held_o == h0, "R8 state unchanged", held_o, h0);
    if (!h0 && !busy_o) chk(cmd_cnt == c0, "R8 no command", cmd_cnt, c0);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7711));
    repeat (3) @(negedge clk);
    tick();
    chk(!grant_o && !held_o && !busy_o && !err_o && !mem_cmd_valid,
        "R1 in reset", {grant_o, held_o, busy_o, err_o, mem_cmd_valid}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) tick();
    chk(!grant_o && !held_o && !busy_o && !err_o && !mem_cmd_valid,
        "R1 after reset", {grant_o, held_o, busy_o, err_o, mem_cmd_valid}, 0);

    // R8: stray release while idle
    stray_release();

    // uncontended acquire, R9 while held, release
    do_acquire(0, 0);
    hold_for(5);
    do_release();

    // R3: lock held elsewhere, engine must only read; R8 during polling
    sem = 1'b0; other_holds = 1; pin = 1;
    @(negedge clk) acq_i = 1'b1;
    @(negedge clk) acq_i = 1'b0;
    repeat (20) tick();
    chk(busy_o && !held_o, "R3 spinning", busy_o, 1);
    stray_release();
    pin = 0;
    for (int i = 0; i < 3000 && !held_o; i++) tick();
    chk(held_o, "R3 eventually held", held_o, 1);
    do_release();

    // R5: forced lost race
    do_acquire(0, 1);
    do_release();

    // random mix
    for (int it = 0; it < 60; it++) begin
      do_acquire(($urandom % 2) == 1, ($urandom % 4) == 0);
      if ($urandom % 3 == 0) hold_for(1 + $urandom % 8);
      else repeat (1 + $urandom % 6) tick();
      do_release();
      if ($urandom % 5 == 0) stray_release();
    end

    repeat (5) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule